// File: doc/BRIEF.md
# Memory-Mapped Parallel I/O with Edge Capture

This block is a general-purpose parallel I/O port of 1 to 32 pins. Software reaches it through a small word-addressed register bus. Through that bus it sets the value each pin drives, chooses which pins are outputs, and reads back the live pin levels. It also enables interrupts per pin. The block drives an output value and an output-enable for every pin, so a pad ring can build a tri-state buffer from the pair. Input levels pass through a two-flop synchroniser before any logic uses them.

Pins can raise one combined interrupt line. The trigger type is fixed when the block is built: rising edge, falling edge, either edge, or high level. In the three edge types, each qualifying transition sets a sticky per-pin capture bit. Software clears a capture bit by writing a 1 to its position. The interrupt line is high while any captured bit is also enabled. In the level type no capture takes place: the interrupt line is high while any enabled pin reads high.

Top module: `pio_edge_ctrl`

## Requirements
- R1: After reset, the direction, enable and capture registers all read zero, pin_oe is all zero and irq is low.
- R2: Word index bus_addr selects the register: 0 is pin data, 1 is direction, 2 is interrupt enable and 3 is capture. Direction and enable read back the value last written.
- R3: A read at index 0 returns the pin_in levels through a two-flop synchroniser. A change of pin_in is not visible after the first rising clock edge. It is visible after the second.
- R4: A write at index 0 sets pin_out. A 1 written to a direction bit drives pin_oe high for that pin, and a 0 drives it low.
- R5: A pin whose interrupt-enable bit is 0 never raises irq, even when its capture bit or its level is set.
- R6: In rising mode only a 0-to-1 transition sets a capture bit. In falling mode only a 1-to-0 transition sets one. In both mode either transition sets one.
- R7: In the edge modes, writing at index 3 clears each capture bit where the written data holds a 1, and leaves the bits where it holds a 0 unchanged.
- R8: In the edge modes, irq is high while any bit of (capture AND enable) is set. A capture bit stays set after the pin returns to its earlier level.
- R9: In level mode, irq is high while any bit of (synchronised pin data AND enable) is set, and the capture register reads zero.
- R10: If a new edge and a clearing write reach the same capture bit in the same cycle, the bit stays set.
- R11: Register bits at and above PIN_COUNT read as zero and ignore writes.
- R12: A bus cycle with bus_sel low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Bus cycle select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | PIN_COUNT | Pin levels from the pads |
| pin_out | output | PIN_COUNT | Value driven on output pins |
| pin_oe | output | PIN_COUNT | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
Suppose a capture bit is set or cleared wrongly. In the edge modes the fault shows on irq as soon as that pin is enabled, and on a read of index 3 in the same cycle. A lost bit is never recovered, because nothing sets it again without a new edge. A synchroniser stage that is missing or extra moves the data readback by one cycle. It also moves the moment a capture bit appears, so the bench samples the readback at a fixed edge count after a pin change. A corrupt direction register shows on pin_oe in the cycle after the write.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int BUS_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } pio_trig_e;

  localparam logic [ADDR_W-1:0] IDX_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] IDX_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] IDX_MASK = 2'd2;
  localparam logic [ADDR_W-1:0] IDX_CAP  = 2'd3;
endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_q & ~prev_q;
  assign fall_o = ~lvl_q & prev_q;

  // R3: synchronised level equals the pin two edges earlier
  a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> (lvl_q == $past(pin_i, 2)));
endmodule

// File: rtl/pio_capture.sv
module pio_capture
  import pio_pkg::*;
#(
  parameter int        W       = 32,
  parameter pio_trig_e TRIGGER = TRIG_RISE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] cap_o
);
  localparam bit IS_EDGE = (TRIGGER != TRIG_LEVEL);

  logic [W-1:0] hit_w, cap_q, cap_d;

  generate
    if (TRIGGER == TRIG_RISE) begin : g_rise
      assign hit_w = rise_i & ~(fall_i & '0);
    end else if (TRIGGER == TRIG_FALL) begin : g_fall
      assign hit_w = fall_i & ~(rise_i & '0);
    end else if (TRIGGER == TRIG_BOTH) begin : g_both
      assign hit_w = rise_i | fall_i;
    end else begin : g_none
      assign hit_w = (rise_i | fall_i) & '0;
    end
  endgenerate

  // new edge wins over a clearing write to the same bit
  always_comb begin
    if (IS_EDGE) cap_d = (cap_q & ~clr_i) | hit_w;
    else         cap_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  assign cap_o = cap_q;

  // R10: a bit hit by an edge is set in the next cycle whatever the clear
  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w != '0) |=> ((cap_q & $past(hit_w)) == $past(hit_w)));
  // R7: cleared bits without a new edge read zero afterwards
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~hit_w) != '0) |=> ((cap_q & $past(clr_i & ~hit_w)) == '0));
  // R6: a capture bit only turns on because of a qualifying edge
  a_r6_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((cap_q & ~$past(cap_q) & ~$past(hit_w)) == '0));
endmodule

// File: rtl/pio_edge_ctrl.sv
module pio_edge_ctrl
  import pio_pkg::*;
#(
  parameter int        PIN_COUNT = 32,
  parameter pio_trig_e TRIGGER   = TRIG_RISE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe,
  output logic                 irq
);
  localparam int W = PIN_COUNT;

  generate
    if (W < 1 || W > BUS_W) begin : g_bad_width
      $error("PIN_COUNT must lie in 1..32");
    end
  endgenerate

  logic         rst_n_s;
  logic         wr_en;
  logic [W-1:0] wfield;
  logic [W-1:0] lvl_w, rise_w, fall_w, cap_w, clr_w;
  logic [W-1:0] out_q, out_d, dir_q, dir_d, mask_q, mask_d;

  pio_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  pio_in_sync #(.W(W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .pin_i  (pin_in),
    .lvl_o  (lvl_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  assign wr_en  = bus_sel & bus_wr;
  assign wfield = bus_wdata[W-1:0];
  assign clr_w  = (wr_en && bus_addr == IDX_CAP) ? wfield : '0;

  pio_capture #(.W(W), .TRIGGER(TRIGGER)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .rise_i (rise_w),
    .fall_i (fall_w),
    .clr_i  (clr_w),
    .cap_o  (cap_w)
  );

  always_comb begin
    out_d  = (wr_en && bus_addr == IDX_DATA) ? wfield : out_q;
    dir_d  = (wr_en && bus_addr == IDX_DIR)  ? wfield : dir_q;
    mask_d = (wr_en && bus_addr == IDX_MASK) ? wfield : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else begin
      out_q  <= out_d;
      dir_q  <= dir_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IDX_DATA: bus_rdata[W-1:0] = lvl_w;
      IDX_DIR:  bus_rdata[W-1:0] = dir_q;
      IDX_MASK: bus_rdata[W-1:0] = mask_q;
      default:  bus_rdata[W-1:0] = cap_w;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  generate
    if (TRIGGER == TRIG_LEVEL) begin : g_irq_level
      assign irq = |(lvl_w & mask_q);
      // R9: irq can only rise with some pin enabled
      a_r9_needs_enable: assert property (@(posedge clk) disable iff (!rst_n_s)
        $rose(irq) |-> (mask_q != '0));
    end else begin : g_irq_edge
      assign irq = |(cap_w & mask_q);
      // R8: in edge modes irq only drops after a capture or enable write
      a_r8_sticky_irq: assert property (@(posedge clk) disable iff (!rst_n_s)
        $fell(irq) |-> $past(wr_en && (bus_addr == IDX_CAP || bus_addr == IDX_MASK)));
    end
  endgenerate

  // R4: a direction write shows on pin_oe in the next cycle
  a_r4_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && bus_addr == IDX_DIR) |=> (pin_oe == $past(wfield)));
  // R12: without a select the enable register holds
  a_r12_no_sel_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!bus_sel && $past(rst_n_s)) |=> $stable(mask_q));
endmodule

// File: tb/pio_edge_ctrl_tb_top.sv
module pio_edge_ctrl_tb_top;
  import pio_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 12;

  logic clk, rst_n, bus_sel, bus_wr;
  logic [1:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [NP-1:0] pin_in;
  logic [31:0] rd_rise, rd_fall, rd_both, rd_lvl;
  logic [NP-1:0] out_rise, oe_rise, out_fall, oe_fall, out_both, oe_both, out_lvl, oe_lvl;
  logic irq_rise, irq_fall, irq_both, irq_lvl;
  int n_chk, n_fail;

  pio_edge_ctrl #(.PIN_COUNT(NP), .TRIGGER(TRIG_RISE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_rise), .pin_in(pin_in), .pin_out(out_rise),
    .pin_oe(oe_rise), .irq(irq_rise));
  pio_edge_ctrl #(.PIN_COUNT(NP), .TRIGGER(TRIG_FALL)) dut_fall_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_fall), .pin_in(pin_in), .pin_out(out_fall),
    .pin_oe(oe_fall), .irq(irq_fall));
  pio_edge_ctrl #(.PIN_COUNT(NP), .TRIGGER(TRIG_BOTH)) dut_both_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_both), .pin_in(pin_in), .pin_out(out_both),
    .pin_oe(oe_both), .irq(irq_both));
  pio_edge_ctrl #(.PIN_COUNT(NP), .TRIGGER(TRIG_LEVEL)) dut_lvl_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_lvl), .pin_in(pin_in), .pin_out(out_lvl),
    .pin_oe(oe_lvl), .irq(irq_lvl));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] idx, input logic [31:0] val, input logic sel);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_addr = idx; bus_wdata = val;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] idx);
    @(negedge clk);
    bus_addr = idx;
    #1;
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (5) @(posedge clk);
  endtask

  task automatic t_reset;
    bus_read(IDX_DIR);  chk("R1 dir", rd_rise, 0);
    bus_read(IDX_MASK); chk("R1 mask", rd_rise, 0);
    bus_read(IDX_CAP);  chk("R1 cap", rd_both, 0);
    chk("R1 pin_oe", {20'd0, oe_rise}, 0);
    chk("R1 irq", {28'd0, irq_rise, irq_fall, irq_both, irq_lvl}, 0);
  endtask

  task automatic t_map;
    bus_write(IDX_DIR, 32'h0000_0A5A, 1'b1);
    bus_write(IDX_MASK, 32'h0000_03C3, 1'b0);   // no select
    bus_read(IDX_MASK); chk("R12 unselected write", rd_rise, 0);
    bus_write(IDX_MASK, 32'h0000_03C3, 1'b1);
    bus_read(IDX_DIR);  chk("R2 dir readback", rd_rise, 32'h0A5A);
    bus_read(IDX_MASK); chk("R2 mask readback", rd_rise, 32'h03C3);
    chk("R4 pin_oe", {20'd0, oe_rise}, 32'h0A5A);
    bus_write(IDX_DATA, 32'h0000_0123, 1'b1);
    chk("R4 pin_out", {20'd0, out_rise}, 32'h0123);
    bus_write(IDX_DIR, 32'hFFFF_FFFF, 1'b1);
    bus_read(IDX_DIR);  chk("R11 upper dir bits", rd_rise, 32'h0FFF);
    bus_write(IDX_DIR, 32'h0, 1'b1);
    chk("R4 pin_oe cleared", {20'd0, oe_rise}, 0);
    bus_write(IDX_MASK, 32'h0, 1'b1);
  endtask

  task automatic t_readback;
    @(negedge clk);
    pin_in = 12'h5A5;
    bus_read(IDX_DATA); chk("R3 one edge not visible", rd_rise, 0);
    bus_read(IDX_DATA); chk("R3 two edges visible", rd_rise, 32'h05A5);
    set_pins(12'h000);
    bus_read(IDX_DATA); chk("R3 pins low", rd_rise, 0);
    bus_read(IDX_CAP);
    chk("R6 rise after pulse", rd_rise, 32'h05A5);
    chk("R6 fall after pulse", rd_fall, 32'h05A5);
    chk("R9 level cap zero", rd_lvl, 0);
    bus_write(IDX_CAP, 32'hFFFF_FFFF, 1'b1);
    bus_read(IDX_CAP);
    chk("R7 clear all", rd_both, 0);
    bus_read(IDX_DATA); chk("R11 upper data bits", rd_rise & 32'hFFFF_F000, 0);
  endtask

  task automatic t_edges;
    set_pins(12'h003);
    bus_read(IDX_CAP);
    chk("R6 rise 0to1", rd_rise, 3); chk("R6 fall 0to1", rd_fall, 0); chk("R6 both 0to1", rd_both, 3);
    set_pins(12'h001);
    bus_read(IDX_CAP);
    chk("R6 rise 1to0", rd_rise, 3); chk("R6 fall 1to0", rd_fall, 2); chk("R6 both 1to0", rd_both, 3);
    chk("R5 masked irq", {28'd0, irq_rise, irq_fall, irq_both, irq_lvl}, 0);
    bus_write(IDX_MASK, 32'h2, 1'b1);
    chk("R8 irq mask2", {28'd0, irq_rise, irq_fall, irq_both, irq_lvl}, 4'b1110);
    bus_write(IDX_MASK, 32'h1, 1'b1);
    chk("R8 R9 irq mask1", {28'd0, irq_rise, irq_fall, irq_both, irq_lvl}, 4'b1011);
  endtask

  task automatic t_w1c;
    bus_write(IDX_CAP, 32'h1, 1'b1);
    bus_read(IDX_CAP);
    chk("R7 partial clear", rd_rise, 2); chk("R7 both partial", rd_both, 2);
    chk("R8 irq drops", {31'd0, irq_rise}, 0);
    bus_write(IDX_CAP, 32'h0, 1'b1);
    bus_read(IDX_CAP); chk("R7 zero write keeps", rd_rise, 2);
  endtask

  task automatic t_collide;
    @(negedge clk);
    pin_in = 12'h005;
    @(posedge clk);
    @(posedge clk);
    bus_write(IDX_CAP, 32'h4, 1'b1);   // lands in the cycle bit 2 is captured
    bus_read(IDX_CAP);
    chk("R10 edge beats clear", rd_rise, 6); chk("R10 both", rd_both, 6);
    bus_write(IDX_CAP, 32'h4, 1'b1);
    bus_read(IDX_CAP); chk("R7 later clear", rd_rise, 2);
  endtask

  task automatic t_level;
    chk("R9 level high", {31'd0, irq_lvl}, 1);
    set_pins(12'h000);
    chk("R9 level low", {31'd0, irq_lvl}, 0);
    chk("R5 rise cap not enabled", {31'd0, irq_rise}, 0);
    bus_write(IDX_MASK, 32'h2, 1'b1);
    chk("R8 sticky capture irq", {31'd0, irq_rise}, 1);
    chk("R9 level ignores capture", {31'd0, irq_lvl}, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pin_in = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_map();
    t_readback();
    t_edges();
    t_w1c();
    t_collide();
    t_level();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule